// File: doc/BRIEF.md
# Multi-register stack transfer sequencer

This block expands one block-transfer request into a run of single-word memory accesses against a full-descending stack. A request names an operation (push or pop) and a 16-bit mask with one bit per register. The block holds the stack pointer itself. For each selected register it drives one memory strobe carrying a word address and a register index. On a push the index selects the register whose value is written. On a pop it names the register that receives the returned word, and the load result comes back through a writeback port one cycle later.

When the transfer ends, the block moves the stack pointer to its final value. Register lists that the stack convention forbids are refused before any memory is touched. A pop that loads the program counter (register 15) writes no register. It either asks for a branch to the loaded address with bit 0 cleared, or reports a fault when bit 0 of the loaded word is 0. The block drives no condition-flag outputs. Choosing the branch, applying it, and the bus work behind the memory port are done outside this block.

Top module: `stk_xfer_seq`

## Requirements
- R1: A push with n selected registers issues n stores (`mem_we`=1) on consecutive cycles, from the highest-numbered register down to the lowest. The first store goes to SP-4, each later store 4 lower, and `mem_idx` carries the register number.
- R2: A pop with n selected registers issues n loads (`mem_we`=0) on consecutive cycles, from the lowest-numbered register up to the highest. The first load goes to SP, each later load 4 higher.
- R3: One cycle after a load strobe for a register other than 15, `ld_we` is 1, `ld_idx` names that register and `ld_data` equals `mem_rdata`.
- R4: SP resets to `SP_RESET`. It becomes SP-4n after a push and SP+4n after a pop, with the new value first visible in the cycle where `done` is 1. At all other times SP is unchanged.
- R5: Any mask with bit 13 set is refused for both push and pop.
- R6: A push mask with bit 15 set is refused.
- R7: A pop mask with both bit 14 and bit 15 set is refused. A pop of bit 14 alone, a pop of bit 15 alone, and a push containing bit 14 are all accepted.
- R8: An all-zero mask is refused.
- R9: A refused request gives a one-cycle `err` pulse in the cycle after acceptance. It makes no memory strobe, leaves SP unchanged, and keeps `req_ready` high.
- R10: `req_ready` is high only while idle. After an accepted legal request of n registers, `req_ready` is low for n+1 cycles. It returns high in the cycle where `done` pulses, and a request waiting at that point is accepted there.
- R11: When a pop loads register 15 and bit 0 of the word is 1, `br_req` pulses in the response cycle, `br_target` is the word with bit 0 cleared, and `ld_we` stays 0.
- R12: When a pop loads register 15 and bit 0 of the word is 0, `br_fault` pulses in the response cycle and `br_req` and `ld_we` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_pop | input | 1 | 1 = pop, 0 = push |
| req_mask | input | 16 | Register list, bit i selects register i |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | 32 | Word byte address |
| mem_idx | output | 4 | Register for store data or load destination |
| mem_rdata | input | 32 | Load data, valid the cycle after a load strobe |
| ld_we | output | 1 | Register writeback enable |
| ld_idx | output | 4 | Register being written |
| ld_data | output | 32 | Data being written |
| br_req | output | 1 | Branch request from a program-counter load |
| br_fault | output | 1 | Program-counter load with bit 0 clear |
| br_target | output | 32 | Loaded word with bit 0 cleared |
| sp | output | 32 | Current stack pointer |
| done | output | 1 | Transfer complete pulse |
| err | output | 1 | Refused request pulse |

## Verification
Pushes and pops with sparse masks, single-register masks and a nearly full mask show whether the register ordering and the address direction are each right. They also separate a count error in the start address from an error in the per-access stride. Each forbidden combination is paired with a close legal one (bit 14 alone against bits 14 and 15 on a pop, bit 14 on a push), which isolates the legality checks from each other. Program-counter pops with the low bit set and with it clear tell the branch path from the fault path. A request held valid while a transfer is running checks the hand-off in the cycle where the transfer completes.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_DRAIN = 2'd2
  } stk_state_e;
endpackage

// File: rtl/stk_mask_chk.sv
// Legality of a register list against the stack rules, plus its population count.
module stk_mask_chk #(
  parameter int NREG   = 16,
  parameter int SP_IDX = 13,
  parameter int LR_IDX = 14,
  parameter int PC_IDX = 15,
  localparam int CW    = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0] mask,
  input  logic            pop,
  output logic            legal,
  output logic [CW-1:0]   count
);
  logic has_sp, bad_push, bad_pop;

  always_comb begin
    count = '0;
    for (int i = 0; i < NREG; i++) count = count + CW'(mask[i]);
  end

  assign has_sp   = mask[SP_IDX];
  assign bad_push = !pop && mask[PC_IDX];
  assign bad_pop  = pop && mask[PC_IDX] && mask[LR_IDX];
  assign legal    = (mask != '0) && !has_sp && !bad_push && !bad_pop;
endmodule

// File: rtl/stk_pick.sv
// Selects the next register of a list: highest first when from_top, else lowest first.
module stk_pick #(
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask,
  input  logic            from_top,
  output logic [IW-1:0]   idx,
  output logic            last
);
  logic [IW-1:0] lo_idx, hi_idx;

  always_comb begin
    lo_idx = '0;
    for (int i = NREG - 1; i >= 0; i--) if (mask[i]) lo_idx = IW'(i);
  end

  always_comb begin
    hi_idx = '0;
    for (int i = 0; i < NREG; i++) if (mask[i]) hi_idx = IW'(i);
  end

  assign idx  = from_top ? hi_idx : lo_idx;
  assign last = ($countones(mask) == 1);
endmodule

// File: rtl/stk_xfer_seq.sv
module stk_xfer_seq
  import stk_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          NREG       = 16,
  parameter int          WORD_BYTES = 4,
  parameter int          SP_IDX     = 13,
  parameter int          LR_IDX     = 14,
  parameter int          PC_IDX     = 15,
  parameter logic [31:0] SP_RESET   = 32'h2000_1000,
  localparam int         IW         = $clog2(NREG),
  localparam int         CW         = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_pop,
  input  logic [NREG-1:0] req_mask,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [IW-1:0]   mem_idx,
  input  logic [AW-1:0]   mem_rdata,
  output logic            ld_we,
  output logic [IW-1:0]   ld_idx,
  output logic [AW-1:0]   ld_data,
  output logic            br_req,
  output logic            br_fault,
  output logic [AW-1:0]   br_target,
  output logic [AW-1:0]   sp,
  output logic            done,
  output logic            err
);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  stk_state_e      state_q, state_n;
  logic [NREG-1:0] rem_q, rem_n;
  logic            pop_q, pop_n;
  logic [AW-1:0]   addr_q, addr_n;
  logic [AW-1:0]   newsp_q, newsp_n;
  logic [AW-1:0]   sp_q;
  logic            sp_en;
  logic            err_q, err_n, done_q, done_n;
  logic            rsp_q, rsp_n;
  logic [IW-1:0]   rsp_idx_q, rsp_idx_n;

  logic            legal;
  logic [CW-1:0]   cnt;
  logic [AW-1:0]   span;
  logic [IW-1:0]   pick_idx;
  logic            pick_last;
  logic            accept;

  stk_mask_chk #(.NREG(NREG), .SP_IDX(SP_IDX), .LR_IDX(LR_IDX), .PC_IDX(PC_IDX)) i_chk (
    .mask (req_mask),
    .pop  (req_pop),
    .legal(legal),
    .count(cnt)
  );

  stk_pick #(.NREG(NREG)) i_pick (
    .mask    (rem_q),
    .from_top(!pop_q),
    .idx     (pick_idx),
    .last    (pick_last)
  );

  assign span   = AW'(cnt) * STEP;
  assign accept = req_valid && (state_q == ST_IDLE);

  // next-state logic
  always_comb begin
    state_n   = state_q;
    rem_n     = rem_q;
    pop_n     = pop_q;
    addr_n    = addr_q;
    newsp_n   = newsp_q;
    err_n     = 1'b0;
    done_n    = 1'b0;
    rsp_n     = 1'b0;
    rsp_idx_n = rsp_idx_q;
    sp_en     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (legal) begin
            state_n = ST_BUSY;
            rem_n   = req_mask;
            pop_n   = req_pop;
            addr_n  = req_pop ? sp_q : sp_q - STEP;
            newsp_n = req_pop ? sp_q + span : sp_q - span;
          end else begin
            err_n = 1'b1;
          end
        end
      end
      ST_BUSY: begin
        rem_n           = rem_q;
        rem_n[pick_idx] = 1'b0;
        addr_n          = pop_q ? addr_q + STEP : addr_q - STEP;
        rsp_n           = pop_q;
        rsp_idx_n       = pick_idx;
        if (pick_last) state_n = ST_DRAIN;
      end
      ST_DRAIN: begin
        state_n = ST_IDLE;
        done_n  = 1'b1;
        sp_en   = 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rem_q     <= '0;
      pop_q     <= 1'b0;
      addr_q    <= '0;
      newsp_q   <= '0;
      sp_q      <= AW'(SP_RESET);
      err_q     <= 1'b0;
      done_q    <= 1'b0;
      rsp_q     <= 1'b0;
      rsp_idx_q <= '0;
    end else begin
      state_q   <= state_n;
      rem_q     <= rem_n;
      pop_q     <= pop_n;
      addr_q    <= addr_n;
      newsp_q   <= newsp_n;
      err_q     <= err_n;
      done_q    <= done_n;
      rsp_q     <= rsp_n;
      rsp_idx_q <= rsp_idx_n;
      if (sp_en) sp_q <= newsp_q;
    end
  end

  // outputs
  assign req_ready = (state_q == ST_IDLE);
  assign mem_req   = (state_q == ST_BUSY);
  assign mem_we    = mem_req && !pop_q;
  assign mem_addr  = addr_q;
  assign mem_idx   = pick_idx;

  assign ld_we     = rsp_q && (rsp_idx_q != IW'(PC_IDX));
  assign ld_idx    = rsp_idx_q;
  assign ld_data   = mem_rdata;
  assign br_req    = rsp_q && (rsp_idx_q == IW'(PC_IDX)) && mem_rdata[0];
  assign br_fault  = rsp_q && (rsp_idx_q == IW'(PC_IDX)) && !mem_rdata[0];
  assign br_target = {mem_rdata[AW-1:1], 1'b0};

  assign sp   = sp_q;
  assign done = done_q;
  assign err  = err_q;

  // assertions
  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  p_ready_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  p_sp_moves_at_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp) |-> done);

  p_refuse_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!mem_req && req_ready && $stable(sp)));

  p_bad_list_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !legal) |=> err);

  p_push_walk_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && $past(mem_req)) |->
      (mem_addr == $past(mem_addr) - STEP) && (mem_idx < $past(mem_idx)));

  p_pop_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && $past(mem_req)) |->
      (mem_addr == $past(mem_addr) + STEP) && (mem_idx > $past(mem_idx)));
endmodule

// File: tb/test_stk_xfer_seq.sv
module test_stk_xfer_seq;
  localparam logic [31:0] SPR = 32'h2000_1000;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_pop;
  logic [15:0] req_mask;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_rdata;
  logic [3:0]  mem_idx;
  logic        ld_we;
  logic [3:0]  ld_idx;
  logic [31:0] ld_data;
  logic        br_req, br_fault;
  logic [31:0] br_target, sp;
  logic        done, err;

  stk_xfer_seq #(.SP_RESET(SPR)) i_stk_xfer_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_pop(req_pop), .req_mask(req_mask),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_idx(mem_idx),
    .mem_rdata(mem_rdata),
    .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
    .br_req(br_req), .br_fault(br_fault), .br_target(br_target),
    .sp(sp), .done(done), .err(err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_tag = "R9";
  logic [31:0] pc_addr = 32'hFFFF_FFFF, pc_val = 32'h0;

  function automatic logic [31:0] memw(logic [31:0] a);
    if (a == pc_addr) return pc_val;
    return {a[15:0] ^ 16'hC3C3, a[15:0]};
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // reference model
  typedef struct { logic [31:0] a; int idx; bit we; } acc_t;
  acc_t        q[$];
  int          m_state = 0;
  bit          m_pop = 0;
  logic [31:0] m_sp = SPR, m_newsp = SPR;
  bit          e_err = 0, e_done = 0, e_ldwe = 0, e_br = 0, e_fault = 0;
  int          e_ldidx = 0;
  logic [31:0] e_lddata = 0, e_tgt = 0;

  always @(posedge clk) begin
    cyc++;
    e_err = 0; e_done = 0; e_ldwe = 0; e_br = 0; e_fault = 0;
    if (!rst_n) begin
      q.delete(); m_state = 0; m_sp = SPR;
    end else if (m_state == 1) begin
      acc_t a;
      logic [31:0] d;
      a = q.pop_front();
      if (!a.we) begin
        d = memw(a.a);
        if (a.idx == 15) begin
          if (d[0]) e_br = 1; else e_fault = 1;
          e_tgt = d & 32'hFFFF_FFFE;
        end else begin
          e_ldwe = 1; e_ldidx = a.idx; e_lddata = d;
        end
      end
      if (q.size() == 0) m_state = 2;
    end else if (m_state == 2) begin
      e_done = 1; m_sp = m_newsp; m_state = 0;
    end else if (req_valid) begin
      bit bad;
      int n;
      bad = (req_mask == 0) || req_mask[13] || (!req_pop && req_mask[15]) ||
            (req_pop && req_mask[15] && req_mask[14]);
      if (bad) e_err = 1;
      else begin
        n = $countones(req_mask);
        m_pop = req_pop;
        if (req_pop) begin
          logic [31:0] a0;
          a0 = m_sp;
          for (int i = 0; i < 16; i++)
            if (req_mask[i]) begin q.push_back('{a0, i, 1'b0}); a0 += 4; end
          m_newsp = m_sp + 32'(4 * n);
        end else begin
          logic [31:0] a0;
          a0 = m_sp - 4;
          for (int i = 15; i >= 0; i--)
            if (req_mask[i]) begin q.push_back('{a0, i, 1'b1}); a0 -= 4; end
          m_newsp = m_sp - 32'(4 * n);
        end
        m_state = 1;
      end
    end
  end

  // memory responder
  always @(negedge clk) begin
    #1;
    if (mem_req && !mem_we) mem_rdata = memw(mem_addr);
  end

  // comparison every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_ready == (m_state == 0), "R10", "req_ready", 32'(req_ready), 32'(m_state == 0));
      chk(mem_req == (m_state == 1), m_pop ? "R2" : "R1", "mem_req", 32'(mem_req), 32'(m_state == 1));
      if (m_state == 1 && q.size() > 0) begin
        chk(mem_addr == q[0].a, m_pop ? "R2" : "R1", "mem_addr", mem_addr, q[0].a);
        chk(int'(mem_idx) == q[0].idx, m_pop ? "R2" : "R1", "mem_idx", 32'(mem_idx), 32'(q[0].idx));
        chk(mem_we == q[0].we, m_pop ? "R2" : "R1", "mem_we", 32'(mem_we), 32'(q[0].we));
      end
      chk(err == e_err, cur_tag, "err", 32'(err), 32'(e_err));
      chk(done == e_done, "R10", "done", 32'(done), 32'(e_done));
      chk(sp == m_sp, "R4", "sp", sp, m_sp);
      chk(ld_we == e_ldwe, "R3", "ld_we", 32'(ld_we), 32'(e_ldwe));
      if (e_ldwe) begin
        chk(int'(ld_idx) == e_ldidx, "R3", "ld_idx", 32'(ld_idx), 32'(e_ldidx));
        chk(ld_data == e_lddata, "R3", "ld_data", ld_data, e_lddata);
      end
      chk(br_req == e_br, "R11", "br_req", 32'(br_req), 32'(e_br));
      chk(br_fault == e_fault, "R12", "br_fault", 32'(br_fault), 32'(e_fault));
      if (e_br || e_fault) chk(br_target == e_tgt, "R11", "br_target", br_target, e_tgt);
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic send(bit pop, logic [15:0] mask, string tag);
    @(negedge clk); #1;
    cur_tag = tag; req_valid = 1; req_pop = pop; req_mask = mask;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    req_valid = 0; req_mask = '0;
  endtask

  task automatic settle();
    @(negedge clk); #1;
    while (!req_ready) begin @(negedge clk); #1; end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_pop = 0; req_mask = '0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(sp == SPR, "R4", "reset sp", sp, SPR);
    chk(req_ready && !mem_req && !done && !err, "R10", "reset idle", 32'(req_ready), 32'd1);

    send(0, 16'h00F1, "R1"); settle();                 // push r0,r4-r7
    send(1, 16'h00F1, "R2"); settle();                 // pop same, data check R3
    send(0, 16'h4004, "R7"); settle();                 // push r2,lr accepted
    send(1, 16'h4004, "R3"); settle();
    send(0, 16'h8001, "R6"); settle();                 // push pc refused
    send(0, 16'h2000, "R5"); settle();                 // push sp refused
    send(1, 16'h2001, "R5"); settle();                 // pop with sp refused
    send(1, 16'hC000, "R7"); settle();                 // pop lr+pc refused
    send(0, 16'h0000, "R8"); settle();                 // empty refused
    send(1, 16'h0000, "R8"); settle();
    send(0, 16'h5FFF, "R1"); settle();                 // nearly full push
    send(1, 16'h4000, "R7"); settle();                 // pop lr alone accepted
    pc_addr = sp + 8; pc_val = 32'h0000_4321;          // bit0 = 1
    send(1, 16'h8401, "R11"); settle();                // pop r0,r10,pc
    pc_addr = sp; pc_val = 32'h0000_8888;              // bit0 = 0
    send(1, 16'h8000, "R12"); settle();                // pop pc alone
    send(0, 16'h0006, "R10");                          // back-to-back hand-off
    send(1, 16'h0006, "R10");
    send(0, 16'h2000, "R9");                           // refused while waiting
    settle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule